// File: doc/BRIEF.md
# Priority-Weighted Decode Slot Arbiter for Two Sibling Threads

This block decides, every clock cycle, which of two hardware threads sharing one core may use the instruction-decode slot. Each thread carries a 3-bit priority written by software. When both threads run, the gap between their priorities fixes a deterministic share of decode cycles. The lower thread gets one slot in every 2^d cycles, where d is the gap. The higher thread gets the remaining slots. Equal priorities alternate strictly.

A single-thread control hands every slot to one chosen thread. A priority of zero switches a thread off, which has the same effect for its sibling. A slot whose scheduled thread is not ready passes to the sibling when the sibling is ready, so no cycle is lost while either thread can issue. The grant is combinational from the current inputs and a small ratio counter. The counter restarts whenever either priority changes.

Top module: `smt_decode_arbiter`

## Requirements
- R1: `grant` is one-hot or zero, and a grant bit is only ever set for a thread whose ready input is high (bit 0 = thread 0, bit 1 = thread 1).
- R2: A thread whose priority is 0 is off and never granted; its sibling receives every cycle in which it is ready. Levels 1 to 7 are running levels (1 lowest, 4 normal, 7 highest).
- R3: With `solo_en` high, only the thread named by `solo_thr` (0 or 1) can be granted, and it receives every cycle in which it is ready.
- R4: With both threads running at equal priority and both ready, grants alternate every cycle, starting with thread 0 in the first cycle after a counter restart.
- R5: With both threads running at a priority gap d > 0 and both ready, the scheduled thread is the lower-priority one in the cycles whose count since restart (first cycle = count 0) has its low d bits all ones, i.e. counts 2^d-1, 2*2^d-1, and so on. In every other cycle it is the higher-priority one. A gap of 3 gives the lower thread 1 cycle in 8.
- R6: The share depends only on the priority gap: pairs 4/1 and 7/4 produce the same grant counts.
- R7: When the scheduled thread is not ready and its running sibling is ready, the sibling is granted.
- R8: When neither thread is both running and ready, `grant` is 0.
- R9: A change of either priority makes the cycle in which the new value is first present count 0 of the ratio pattern, even when the gap is unchanged.
- R10: While `rst_n` is low, `grant` is 0. The first cycle after reset with nonzero priorities is count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prio_t0 | input | 3 | Priority of thread 0 (0 = off, 1..7) |
| prio_t1 | input | 3 | Priority of thread 1 (0 = off, 1..7) |
| ready_t0 | input | 1 | Thread 0 has an instruction to decode |
| ready_t1 | input | 1 | Thread 1 has an instruction to decode |
| solo_en | input | 1 | Single-thread mode enable |
| solo_thr | input | 1 | Thread that keeps running in single-thread mode |
| grant | output | 2 | One-hot decode grant for this cycle |

## Verification
The bench builds the block with its default 3-bit priority width. That default allows gaps up to six and a 64-cycle ratio window, so the extreme 1-against-7 share is counted over one full window. The grant counts for gaps of one, two, three and six are checked, and the position of the lower thread's slot within the window is checked cycle by cycle. Mid-stream priority changes, with the gap changed and with it kept, show that the window restarts rather than continuing from the old count.

// File: rtl/smt_arb_pkg.sv
// Package: shared constants for the two-thread decode arbiter.
// Assumes exactly two sibling threads; thread index 0 or 1.
package smt_arb_pkg;
    localparam int NUM_THR = 2;
    typedef logic [NUM_THR-1:0] thr_vec_t;
endpackage

// File: rtl/smt_prio_eval.sv
// smt_prio_eval: decides which threads are running and derives the
// priority gap and which sibling is the lower one.
// Assumes priority 0 means off; solo mode forces the other thread off.
module smt_prio_eval
    import smt_arb_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic [PRIO_W-1:0] prio_a,
    input  logic [PRIO_W-1:0] prio_b,
    input  logic              solo_en,
    input  logic              solo_thr,
    output thr_vec_t          active,
    output logic [PRIO_W-1:0] gap,
    output logic              low_thr
);
    // Running flags: nonzero priority and not excluded by solo mode.
    always_comb begin
        active[0] = (prio_a != '0) && !(solo_en && solo_thr);
        active[1] = (prio_b != '0) && !(solo_en && !solo_thr);
    end

    // Absolute priority gap and identity of the lower-priority thread.
    always_comb begin
        if (prio_a >= prio_b) begin
            gap     = prio_a - prio_b;
            low_thr = 1'b1;
        end else begin
            gap     = prio_b - prio_a;
            low_thr = 1'b0;
        end
    end
endmodule

// File: rtl/smt_ratio_cnt.sv
// smt_ratio_cnt: free-running slot counter that restarts at zero in any
// cycle where either priority differs from the value held last cycle.
// Assumes the counter width covers the largest ratio window (wraps).
module smt_ratio_cnt #(
    parameter int PRIO_W = 3,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIO_W-1:0] prio_a,
    input  logic [PRIO_W-1:0] prio_b,
    output logic [CNT_W-1:0]  cnt_now
);
    logic [PRIO_W-1:0] prio_a_q;
    logic [PRIO_W-1:0] prio_b_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              restart;

    // Detect a priority change against last cycle's values.
    always_comb begin
        restart = (prio_a != prio_a_q) || (prio_b != prio_b_q);
        cnt_now = restart ? '0 : cnt_q;
    end

    // Hold previous priorities and advance the count past this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_a_q <= '0;
            prio_b_q <= '0;
            cnt_q    <= '0;
        end else begin
            prio_a_q <= prio_a;
            prio_b_q <= prio_b;
            cnt_q    <= cnt_now + CNT_W'(1);
        end
    end

    // R9
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !restart) |=> (restart || cnt_now == $past(cnt_now) + CNT_W'(1)));
endmodule

// File: rtl/smt_slot_pick.sv
// smt_slot_pick: picks the scheduled thread from the count and gap, then
// passes the slot to the sibling when the scheduled thread cannot issue.
// Assumes gap <= CNT_W so the mask fits the counter.
module smt_slot_pick
    import smt_arb_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int CNT_W  = 6
) (
    input  thr_vec_t          active,
    input  thr_vec_t          ready,
    input  logic [PRIO_W-1:0] gap,
    input  logic              low_thr,
    input  logic [CNT_W-1:0]  cnt,
    output thr_vec_t          pick
);
    logic [CNT_W-1:0] mask;
    logic             low_turn;
    logic             sched;
    thr_vec_t         elig;

    // Mask of the low gap bits; the lower thread's turn is all-ones there.
    always_comb begin
        mask = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(gap)) mask[i] = 1'b1;
        end
        low_turn = ((cnt & mask) == mask);
    end

    // Scheduled thread: ratio pattern when both run, else the running one.
    always_comb begin
        if (active == 2'b11) begin
            if (gap == '0) sched = cnt[0];
            else           sched = low_turn ? low_thr : !low_thr;
        end else begin
            sched = !active[0];
        end
    end

    // Grant the scheduled thread, or hand the slot to a ready sibling.
    always_comb begin
        elig = active & ready;
        pick = '0;
        if (elig[sched])       pick[sched]  = 1'b1;
        else if (elig[!sched]) pick[!sched] = 1'b1;
    end
endmodule

// File: rtl/smt_decode_arbiter.sv
// smt_decode_arbiter: per-cycle decode-slot grant between two sibling
// threads, sharing slots in a ratio set by their priority gap.
// Assumes inputs are synchronous to clk; grant is combinational.
module smt_decode_arbiter
    import smt_arb_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIO_W-1:0] prio_t0,
    input  logic [PRIO_W-1:0] prio_t1,
    input  logic              ready_t0,
    input  logic              ready_t1,
    input  logic              solo_en,
    input  logic              solo_thr,
    output logic [1:0]        grant
);
    localparam int MAX_GAP = (1 << PRIO_W) - 2;
    localparam int CNT_W   = MAX_GAP;

    thr_vec_t          active;
    thr_vec_t          ready;
    thr_vec_t          pick;
    logic [PRIO_W-1:0] gap;
    logic              low_thr;
    logic [CNT_W-1:0]  cnt;

    assign ready = {ready_t1, ready_t0};

    smt_prio_eval #(.PRIO_W(PRIO_W)) u_eval (
        .prio_a  (prio_t0),
        .prio_b  (prio_t1),
        .solo_en (solo_en),
        .solo_thr(solo_thr),
        .active  (active),
        .gap     (gap),
        .low_thr (low_thr)
    );

    smt_ratio_cnt #(.PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .prio_a (prio_t0),
        .prio_b (prio_t1),
        .cnt_now(cnt)
    );

    smt_slot_pick #(.PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_pick (
        .active (active),
        .ready  (ready),
        .gap    (gap),
        .low_thr(low_thr),
        .cnt    (cnt),
        .pick   (pick)
    );

    // Quiet output during reset, otherwise the picker's choice.
    assign grant = rst_n ? pick : 2'b00;

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    for (genvar t = 0; t < 2; t++) begin : g_thr_chk
        // R1
        grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[t] |-> ready[t]);
    end

    // R2
    off_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prio_t0 == '0) |-> !grant[0]) and ((prio_t1 == '0) |-> !grant[1]));

    // R3
    solo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        solo_en |-> !grant[!solo_thr]);

    // R7
    no_waste_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_t0 && prio_t0 != '0 && !(solo_en && solo_thr)) ||
         (ready_t1 && prio_t1 != '0 && !(solo_en && !solo_thr))) |-> (grant != 2'b00));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_t0 && !ready_t1) |-> (grant == 2'b00));

    // R4
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_t0 == prio_t1 && prio_t0 != '0 && !solo_en && ready_t0 && ready_t1 &&
         $stable(prio_t0) && $stable(prio_t1) && $past(rst_n) &&
         $past(ready_t0 && ready_t1 && !solo_en)) |-> (grant != $past(grant)));
endmodule

// File: tb/smt_decode_arbiter_tb.sv
`timescale 1ns/1ps
module smt_decode_arbiter_tb;
    typedef struct packed {
        logic [2:0] p0;
        logic [2:0] p1;
        logic       solo;
        logic       own;
        logic       r0;
        logic       r1;
        logic [7:0] n;
        logic [7:0] e0;
        logic [7:0] e1;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{3'd4, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 8'd16, 8'd8,  8'd8,  4'd4}, // R4 equal
        '{3'd4, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd16, 8'd14, 8'd2,  4'd5}, // R5 gap 3
        '{3'd7, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 8'd16, 8'd14, 8'd2,  4'd6}, // R6 same gap
        '{3'd1, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 8'd64, 8'd1,  8'd63, 4'd5}, // R5 gap 6
        '{3'd3, 3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 8'd16, 8'd4,  8'd12, 4'd5}, // R5 gap 2
        '{3'd5, 3'd6, 1'b0, 1'b0, 1'b1, 1'b1, 8'd16, 8'd8,  8'd8,  4'd5}, // R5 gap 1
        '{3'd4, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd16, 8'd0,  8'd16, 4'd7}, // R7
        '{3'd1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 8'd16, 8'd16, 8'd0,  4'd7}, // R7
        '{3'd4, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'd16, 8'd0,  8'd0,  4'd8}, // R8
        '{3'd0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 8'd16, 8'd0,  8'd16, 4'd2}, // R2
        '{3'd4, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd16, 8'd16, 8'd0,  4'd2}, // R2
        '{3'd2, 3'd6, 1'b1, 1'b0, 1'b1, 1'b1, 8'd16, 8'd16, 8'd0,  4'd3}, // R3
        '{3'd2, 3'd6, 1'b1, 1'b1, 1'b1, 1'b1, 8'd16, 8'd0,  8'd16, 4'd3}  // R3
    };

    logic       clk;
    logic       rst_n;
    logic [2:0] prio_t0;
    logic [2:0] prio_t1;
    logic       ready_t0;
    logic       ready_t1;
    logic       solo_en;
    logic       solo_thr;
    logic [1:0] grant;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [1:0] seq [0:63];

    smt_decode_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .prio_t0(prio_t0), .prio_t1(prio_t1),
        .ready_t0(ready_t0), .ready_t1(ready_t1), .solo_en(solo_en),
        .solo_thr(solo_thr), .grant(grant)
    );

    initial begin
        clk = 1'b0;
        forever #2.5 clk = ~clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] a, input logic [2:0] b,
                         input logic s, input logic o, input logic r0, input logic r1);
        prio_t0 = a; prio_t1 = b; solo_en = s; solo_thr = o;
        ready_t0 = r0; ready_t1 = r1;
    endtask

    // Sample grant for n cycles starting at the current negedge.
    task automatic capture(input int n);
        for (int k = 0; k < n; k++) begin
            #1 seq[k] = grant;
            @(negedge clk);
        end
    endtask

    // One idle cycle with both threads off so the next setting restarts.
    task automatic idle_cycle();
        drive(3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        int c0, c1, bad;
        rst_n = 1'b0;
        drive(3'd4, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        #1 chk("R10 reset grant", grant, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_cycle();

        // Table walk: grant counts per thread over each vector window.
        for (int v = 0; v < NVEC; v++) begin
            idle_cycle();
            drive(VECS[v].p0, VECS[v].p1, VECS[v].solo, VECS[v].own, VECS[v].r0, VECS[v].r1);
            capture(int'(VECS[v].n));
            c0 = 0; c1 = 0; bad = 0;
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                c0 += int'(seq[k][0]);
                c1 += int'(seq[k][1]);
                if (seq[k] == 2'b11) bad++;
                if ((seq[k][0] && !VECS[v].r0) || (seq[k][1] && !VECS[v].r1)) bad++;
            end
            chk($sformatf("R%0d vec%0d thread0 count", VECS[v].req, v), c0, int'(VECS[v].e0));
            chk($sformatf("R%0d vec%0d thread1 count", VECS[v].req, v), c1, int'(VECS[v].e1));
            chk($sformatf("R1 vec%0d onehot/ready violations", v), bad, 0);
        end

        // R4: alternation starts with thread 0 after restart.
        idle_cycle();
        drive(3'd3, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        capture(4);
        chk("R4 first slot", seq[0], 1);
        chk("R4 second slot", seq[1], 2);
        chk("R4 fourth slot", seq[3], 2);

        // R5: gap 3, lower thread (1) owns counts 7 and 15.
        idle_cycle();
        drive(3'd4, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        capture(16);
        chk("R5 count6", seq[6], 1);
        chk("R5 count7", seq[7], 2);
        chk("R5 count15", seq[15], 2);

        // R9: gap changes 3 -> 2 mid-run; window restarts at zero.
        idle_cycle();
        drive(3'd4, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        capture(5);
        drive(3'd4, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1);
        capture(4);
        chk("R9 new gap count2", seq[2], 1);
        chk("R9 new gap count3", seq[3], 2);

        // R9: same gap, new values; still restarts.
        idle_cycle();
        drive(3'd4, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        capture(5);
        drive(3'd5, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1);
        capture(8);
        chk("R9 same gap count2", seq[2], 1);
        chk("R9 same gap count7", seq[7], 2);

        // R10: reset mid-run quiets grant; first cycle afterwards is count 0.
        drive(3'd4, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
        capture(3);
        rst_n = 1'b0;
        #1 chk("R10 grant in reset", grant, 0);
        @(negedge clk);
        rst_n = 1'b1;
        capture(2);
        chk("R10 first after reset", seq[0], 1);
        chk("R10 second after reset", seq[1], 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule